// File: doc/BRIEF.md
# Serial EEPROM Word Read Controller

This block fetches one 16-bit word from a three-wire serial EEPROM of the clocked, chip-selected kind that takes a start bit, an opcode and an address on a single data line. The host presents a word address and pulses a start request for one cycle. The controller then runs the whole exchange without help from the host. It selects the device and clocks out a read command. It then clocks the reply back in, one bit per serial clock period, and releases the device. At the end it raises a one-cycle completion strobe, with the word on a holding register.

The controller also drives a protect-enable line. That line stays high whenever the device is idle and goes low for the length of every transaction. The serial clock rests high between transactions. Every step of the exchange lasts one half-period of the serial clock. That half-period is a parameter counted in system clocks, so one read always takes 62 half-periods.

Top module: `mw_eeprom_reader`

## Requirements
- R1: After reset, and whenever idle, the pins are: select low, serial clock high, protect high, data-out low. Busy and done are low.
- R2: An accepted start first drives data-out, serial clock and protect low together and holds them for two half-periods (a drive step followed by a settling step). Select then rises for one half-period with the clock still low, and then the clock rises for one half-period.
- R3: The command frame is 11 bits, sent most significant bit first. It is a start bit of 1, then the read opcode bits 1 and 0, then an 8-bit address field. The address field holds the 7-bit word address (128 words) with a zero in its top bit. The frame equals the top 11 bits of 0xC000 ORed with the address field shifted left by 5.
- R4: For each command bit, data-out takes the bit while the clock goes low for one half-period. The clock then goes high for one half-period, and data-out does not change at that rising edge.
- R5: After the last command bit, data-out is driven low with the clock still high for one half-period, before the first read clock.
- R6: Exactly 16 read bits follow. For each bit the clock is low for one half-period and then high for one half-period. The data-in pin is sampled in the last system cycle of the high half. Bits fill the word most significant bit first.
- R7: Release runs in this order, one half-period per step: the clock goes low, then select goes low, then protect goes high. After that the clock returns high and the pins are back at the idle state.
- R8: Busy is high from the cycle after an accepted start until the cycle in which done pulses. Done is high for exactly one cycle. The read word changes only in that cycle and holds until the next done.
- R9: A start request in any busy cycle, including the last one, is ignored. The running read continues with its original address.
- R10: Every step lasts exactly DIV_HALF system clocks, so a read occupies 62 × DIV_HALF cycles from acceptance to done.
- R11: A start request in the done cycle is accepted. The next read begins its first step in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle read request, taken only when idle |
| addr_i | input | 7 | Word address, sampled with an accepted start |
| busy_o | output | 1 | High while a read is running |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | 16 | Last word read, held until the next completion |
| sel_o | output | 1 | Device select to the EEPROM |
| sclk_o | output | 1 | Serial clock to the EEPROM, idle high |
| prot_o | output | 1 | Protect-enable line, high when idle |
| mosi_o | output | 1 | Serial data to the EEPROM |
| miso_i | input | 1 | Serial data from the EEPROM |

## Verification
Two events can meet in the same cycle: the completion of one read, and a fresh start request. The bench holds start high in both the final busy cycle and the done cycle. It expects the first of these to be ignored and the second to launch a new read in the very next cycle. It judges the outcome three ways. The first read's word must appear with done. The pins must show the first selection step one cycle after done. The second read must carry the second address in its frame and return that address's word.

// File: rtl/mw_eeprom_pkg.sv
// Package: shared constants, step encoding and pin decode for the serial
// EEPROM read controller. Assumes an 11-bit read frame and an 8-bit
// address field, as fixed by the device's command format.
package mw_eeprom_pkg;

    localparam int FRAME_BITS   = 11;
    localparam int ADDR_FIELD_W = 8;
    localparam int CMD_WORD_W   = 16;
    localparam logic [CMD_WORD_W-1:0] READ_CMD_WORD = 16'hC000;

    // One encoding per half-period step of a read transaction.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL_QUIET,
        ST_SEL_SETTLE,
        ST_SEL_CS,
        ST_SEL_CLK,
        ST_CMD_LO,
        ST_CMD_HI,
        ST_CMD_END,
        ST_RD_LO,
        ST_RD_HI,
        ST_DES_CLK,
        ST_DES_CS,
        ST_DES_PROT
    } step_e;

    // Device-side pin levels for one step.
    typedef struct packed {
        logic sel;
        logic sclk;
        logic prot;
        logic mosi;
    } pins_t;

    // Build the transmitted read frame: top bits of the command word with
    // the address field placed just below the opcode.
    function automatic logic [FRAME_BITS-1:0] make_read_frame(
        input logic [ADDR_FIELD_W-1:0] field
    );
        logic [CMD_WORD_W-1:0] word;
        word = READ_CMD_WORD | (CMD_WORD_W'(field) << (CMD_WORD_W - FRAME_BITS));
        return word[CMD_WORD_W-1 -: FRAME_BITS];
    endfunction

    // Map a step to the levels on the device pins.
    function automatic pins_t step_pins(input step_e s, input logic cmd_bit);
        pins_t p;
        case (s)
            ST_SEL_QUIET,
            ST_SEL_SETTLE: p = '{sel: 1'b0, sclk: 1'b0, prot: 1'b0, mosi: 1'b0};
            ST_SEL_CS:     p = '{sel: 1'b1, sclk: 1'b0, prot: 1'b0, mosi: 1'b0};
            ST_SEL_CLK:    p = '{sel: 1'b1, sclk: 1'b1, prot: 1'b0, mosi: 1'b0};
            ST_CMD_LO:     p = '{sel: 1'b1, sclk: 1'b0, prot: 1'b0, mosi: cmd_bit};
            ST_CMD_HI:     p = '{sel: 1'b1, sclk: 1'b1, prot: 1'b0, mosi: cmd_bit};
            ST_CMD_END:    p = '{sel: 1'b1, sclk: 1'b1, prot: 1'b0, mosi: 1'b0};
            ST_RD_LO:      p = '{sel: 1'b1, sclk: 1'b0, prot: 1'b0, mosi: 1'b0};
            ST_RD_HI:      p = '{sel: 1'b1, sclk: 1'b1, prot: 1'b0, mosi: 1'b0};
            ST_DES_CLK:    p = '{sel: 1'b1, sclk: 1'b0, prot: 1'b0, mosi: 1'b0};
            ST_DES_CS:     p = '{sel: 1'b0, sclk: 1'b0, prot: 1'b0, mosi: 1'b0};
            ST_DES_PROT:   p = '{sel: 1'b0, sclk: 1'b0, prot: 1'b1, mosi: 1'b0};
            default:       p = '{sel: 1'b0, sclk: 1'b1, prot: 1'b1, mosi: 1'b0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/mw_half_timer.sv
// Half-period timer: while run is high, pulses tick once every DIV_HALF
// system clocks. Assumes DIV_HALF >= 1. While run is low the count is
// preloaded, so the first step after run rises lasts a full DIV_HALF.
module mw_half_timer #(
    parameter int DIV_HALF = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt_q;

    // Count down within a step and reload at its end or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= RELOAD;
        else if (!run || cnt_q == '0)
            cnt_q <= RELOAD;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    assign tick = run && (cnt_q == '0);

    // A tick is followed by a full step, so with DIV_HALF > 1 no tick can follow at once.
    assert_tick_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && DIV_HALF > 1) |=> !tick);

endmodule

// File: rtl/mw_cmd_shifter.sv
// Command shifter: holds the read frame and presents its MSB to the data
// line. It shifts once per transmitted bit and flags the final bit.
// Assumes load and shift are never high together.
module mw_cmd_shifter #(
    parameter int BITS = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BITS-1:0] frame_i,
    input  logic            shift,
    output logic            bit_o,
    output logic            last_o
);

    localparam int CW = $clog2(BITS);

    logic [BITS-1:0] sr_q;
    logic [CW-1:0]   cnt_q;

    // Load the frame, or move the next bit into the MSB position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sr_q  <= frame_i;
            cnt_q <= '0;
        end else if (shift) begin
            sr_q  <= {sr_q[BITS-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bit_o  = sr_q[BITS-1];
    assign last_o = (cnt_q == CW'(BITS - 1));

    // The final command bit's shift is never followed directly by another.
    assert_frame_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && last_o) |=> !shift);

    // Load and shift are exclusive requests from the sequencer.
    assert_load_shift_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));

endmodule

// File: rtl/mw_rx_shifter.sv
// Receive shifter: collects read bits MSB first and flags the final bit.
// Assumes clear and sample are never high together.
module mw_rx_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              din,
    output logic [DATA_W-1:0] word_o,
    output logic              last_o
);

    localparam int CW = $clog2(DATA_W);

    logic [DATA_W-1:0] sr_q;
    logic [CW-1:0]     cnt_q;

    // Clear at the start of a read, then append one bit per sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (sample) begin
            sr_q  <= {sr_q[DATA_W-2:0], din};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign word_o = sr_q;
    assign last_o = (cnt_q == CW'(DATA_W - 1));

    // After the final sample, sampling stops until the next clear.
    assert_word_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && last_o) |=> !sample);

endmodule

// File: rtl/mw_eeprom_reader.sv
// Serial EEPROM word read controller (top). Accepts a start request and
// address when idle. It selects the device, sends the read frame, clocks
// in DATA_W bits and releases the device, one step per serial half-period.
// Assumes miso_i is already synchronous to clk and that WORDS needs at
// most 8 address bits.
module mw_eeprom_reader
    import mw_eeprom_pkg::*;
#(
    parameter int  WORDS    = 128,
    parameter int  DATA_W   = 16,
    parameter int  DIV_HALF = 3,
    localparam int ADDR_W   = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              sel_o,
    output logic              sclk_o,
    output logic              prot_o,
    output logic              mosi_o,
    input  logic              miso_i
);

    step_e             state_q, state_d;
    logic              step_tick;
    logic              cmd_load, cmd_shift, cmd_bit, cmd_last;
    logic              rx_clear, rx_sample, rx_last;
    logic [DATA_W-1:0] rx_word;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;
    pins_t             pins;

    // Paces every step of the transaction.
    mw_half_timer #(.DIV_HALF(DIV_HALF)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_o),
        .tick  (step_tick)
    );

    // Holds and serialises the read frame.
    mw_cmd_shifter #(.BITS(FRAME_BITS)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cmd_load),
        .frame_i (make_read_frame(ADDR_FIELD_W'(addr_i))),
        .shift   (cmd_shift),
        .bit_o   (cmd_bit),
        .last_o  (cmd_last)
    );

    // Gathers the returned word.
    mw_rx_shifter #(.DATA_W(DATA_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (rx_clear),
        .sample (rx_sample),
        .din    (miso_i),
        .word_o (rx_word),
        .last_o (rx_last)
    );

    // Choose the next step and the shifter strobes for this cycle.
    always_comb begin
        state_d   = state_q;
        cmd_load  = 1'b0;
        cmd_shift = 1'b0;
        rx_clear  = 1'b0;
        rx_sample = 1'b0;
        if (state_q == ST_IDLE) begin
            if (start_i) begin
                state_d  = ST_SEL_QUIET;
                cmd_load = 1'b1;
                rx_clear = 1'b1;
            end
        end else if (step_tick) begin
            case (state_q)
                ST_SEL_QUIET:  state_d = ST_SEL_SETTLE;
                ST_SEL_SETTLE: state_d = ST_SEL_CS;
                ST_SEL_CS:     state_d = ST_SEL_CLK;
                ST_SEL_CLK:    state_d = ST_CMD_LO;
                ST_CMD_LO:     state_d = ST_CMD_HI;
                ST_CMD_HI: begin
                    cmd_shift = 1'b1;
                    state_d   = cmd_last ? ST_CMD_END : ST_CMD_LO;
                end
                ST_CMD_END:    state_d = ST_RD_LO;
                ST_RD_LO:      state_d = ST_RD_HI;
                ST_RD_HI: begin
                    rx_sample = 1'b1;
                    state_d   = rx_last ? ST_DES_CLK : ST_RD_LO;
                end
                ST_DES_CLK:    state_d = ST_DES_CS;
                ST_DES_CS:     state_d = ST_DES_PROT;
                default:       state_d = ST_IDLE;
            endcase
        end
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Completion strobe and the word holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= (state_q == ST_DES_PROT) && step_tick;
            if ((state_q == ST_DES_PROT) && step_tick)
                rdata_q <= rx_word;
        end
    end

    assign pins    = step_pins(state_q, cmd_bit);
    assign sel_o   = pins.sel;
    assign sclk_o  = pins.sclk;
    assign prot_o  = pins.prot;
    assign mosi_o  = pins.mosi;
    assign busy_o  = (state_q != ST_IDLE);
    assign done_o  = done_q;
    assign rdata_o = rdata_q;

    // Selection and protect are never active together.
    assert_sel_excludes_prot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o |-> !prot_o);

    // Data-out is steady across every rising serial clock edge.
    assert_mosi_steady_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(mosi_o));

    // The serial clock moves only at step boundaries.
    assert_sclk_on_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !step_tick) |=> $stable(sclk_o));

    // Done is a single-cycle pulse.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // The read word changes only together with done.
    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(rdata_o));

    // A start seen while busy leaves the sequence untouched.
    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !step_tick) |=> $stable(state_q));

    // An idle controller shows the resting pin levels.
    assert_idle_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !done_o) |-> (!sel_o && sclk_o && prot_o && !mosi_o));

endmodule

// File: tb/mw_eeprom_reader_test.sv
// Directed bench for the serial EEPROM read controller, with a behavioural
// device model that captures the frame and answers with a known word.
module mw_eeprom_reader_test;

    localparam int DIV   = 3;
    localparam int STEPS = 62;
    localparam int DONE  = STEPS * DIV;
    localparam int TRMAX = DONE + 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  addr = '0;
    logic        busy, done, sel, sclk, prot, mosi;
    logic        miso = 1'b0;
    logic [15:0] rdata;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic [15:0] prev_word = '0;

    logic [3:0]  tr_pins  [TRMAX];
    logic        tr_busy  [TRMAX];
    logic        tr_done  [TRMAX];
    logic [15:0] tr_rdata [TRMAX];

    // Device model state.
    logic        sclk_prev = 1'b1;
    logic [10:0] ee_frame = '0;
    int          ee_rx = 0;
    int          ee_tx = 0;

    mw_eeprom_reader #(.WORDS(128), .DATA_W(16), .DIV_HALF(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
        .busy_o(busy), .done_o(done), .rdata_o(rdata),
        .sel_o(sel), .sclk_o(sclk), .prot_o(prot), .mosi_o(mosi), .miso_i(miso)
    );

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic [15:0] mem_word(input logic [6:0] a);
        return 16'h3C5A ^ {a, 2'b01, ~a};
    endfunction

    function automatic logic [10:0] exp_frame(input logic [6:0] a);
        return {3'b110, 1'b0, a};
    endfunction

    // Expected {sel, sclk, prot, mosi} for a step index.
    function automatic logic [3:0] exp_pins(input int s, input logic [6:0] a);
        logic [10:0] fr;
        fr = exp_frame(a);
        if (s < 2)  return 4'b0000;
        if (s == 2) return 4'b1000;
        if (s == 3) return 4'b1100;
        if (s <= 25) return ((s - 4) % 2 == 0) ? {3'b100, fr[10 - (s - 4) / 2]}
                                                : {3'b110, fr[10 - (s - 4) / 2]};
        if (s == 26) return 4'b1100;
        if (s <= 58) return ((s - 27) % 2 == 0) ? 4'b1000 : 4'b1100;
        if (s == 59) return 4'b1000;
        if (s == 60) return 4'b0000;
        if (s == 61) return 4'b0010;
        return 4'b0110;
    endfunction

    // Device model: waits for the start bit, takes 11 bits on rising
    // edges, then presents read bits after each falling edge.
    always @(posedge clk) begin
        sclk_prev <= sclk;
        if (!sel) begin
            ee_rx <= 0;
            ee_tx <= 0;
        end else if (sclk && !sclk_prev && ee_rx < 11) begin
            if (ee_rx > 0 || mosi) begin
                ee_frame <= {ee_frame[9:0], mosi};
                ee_rx    <= ee_rx + 1;
            end
        end else if (!sclk && sclk_prev && ee_rx == 11 && ee_tx < 16) begin
            miso  <= mem_word(ee_frame[6:0])[15 - ee_tx];
            ee_tx <= ee_tx + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Start a read of a and record n cycles; start is raised again with
    // addr b in cycles inj_a and inj_b.
    task automatic capture(input logic [6:0] a, input int n, input int inj_a,
                           input int inj_b, input logic [6:0] b);
        @(negedge clk);
        addr  = a;
        start = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tr_pins[i]  = {sel, sclk, prot, mosi};
            tr_busy[i]  = busy;
            tr_done[i]  = done;
            tr_rdata[i] = rdata;
            start = (i == inj_a) || (i == inj_b);
            if (start) addr = b;
        end
        start = 1'b0;
    endtask

    // Judge a captured read of address a over trace indices 0..last.
    task automatic check_read(input logic [6:0] a, input int last);
        int   bad_i [6];
        logic [3:0] bad_a [6];
        logic [3:0] bad_e [6];
        int   seg;
        bit   flow_ok;
        bit   hold_ok;
        for (int k = 0; k < 6; k++) bad_i[k] = -1;
        flow_ok = 1'b1;
        hold_ok = 1'b1;
        for (int i = 0; i <= last; i++) begin
            int s;
            s = i / DIV;
            seg = (s < 4) ? 0 : (s < 26) ? 1 : (s == 26) ? 2 : (s < 59) ? 3 : (s < 62) ? 4 : 5;
            if (tr_pins[i] !== exp_pins(s, a) && bad_i[seg] < 0) begin
                bad_i[seg] = i;
                bad_a[seg] = tr_pins[i];
                bad_e[seg] = exp_pins(s, a);
            end
            if (tr_busy[i] !== (i < DONE) || tr_done[i] !== (i == DONE)) flow_ok = 1'b0;
            if (i < DONE && tr_rdata[i] !== prev_word) hold_ok = 1'b0;
        end
        chk(bad_i[0] < 0, "R2", "select order", 32'(bad_a[0]), 32'(bad_e[0]));
        chk(bad_i[1] < 0, "R4", "command bit timing", 32'(bad_a[1]), 32'(bad_e[1]));
        chk(bad_i[2] < 0, "R5", "data-out low after frame", 32'(bad_a[2]), 32'(bad_e[2]));
        chk(bad_i[3] < 0, "R6", "read clocking", 32'(bad_a[3]), 32'(bad_e[3]));
        chk(bad_i[4] < 0, "R7", "release order", 32'(bad_a[4]), 32'(bad_e[4]));
        chk(bad_i[5] < 0, "R1", "idle levels after read", 32'(bad_a[5]), 32'(bad_e[5]));
        chk(flow_ok, "R10", "busy span and done cycle", 32'(flow_ok), 32'd1);
        chk(hold_ok, "R8", "word held during busy", 32'(hold_ok), 32'd1);
        chk(ee_frame === exp_frame(a), "R3", "frame content", 32'(ee_frame), 32'(exp_frame(a)));
        chk(tr_rdata[DONE] === mem_word(a), "R6", "word at done", 32'(tr_rdata[DONE]),
            32'(mem_word(a)));
        prev_word = mem_word(a);
    endtask

    task automatic test_reset();
        chk({sel, sclk, prot, mosi} === 4'b0110, "R1", "pins after reset",
            32'({sel, sclk, prot, mosi}), 32'h6);
        chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done after reset",
            32'({busy, done}), 32'h0);
    endtask

    task automatic test_read(input logic [6:0] a);
        capture(a, DONE + 2, -1, -1, 7'd0);
        check_read(a, DONE + 1);
    endtask

    // Start requests mid-read and in the final busy cycle must not disturb it.
    task automatic test_ignore_busy(input logic [6:0] a, input logic [6:0] b);
        capture(a, DONE + 2, 20 * DIV, DONE - 1, b);
        check_read(a, DONE + 1);
        chk(tr_pins[DONE + 1] === 4'b0110, "R9", "no restart after ignored start",
            32'(tr_pins[DONE + 1]), 32'h6);
    endtask

    // Start in the final busy cycle (ignored) and in the done cycle (taken).
    task automatic test_back_to_back(input logic [6:0] a, input logic [6:0] b);
        int n;
        capture(a, DONE + 3, DONE - 1, DONE, b);
        check_read(a, DONE);
        chk(tr_pins[DONE + 1] === 4'b0000 && tr_busy[DONE + 1] === 1'b1, "R11",
            "new read starts after done", 32'({tr_busy[DONE + 1], tr_pins[DONE + 1]}), 32'h10);
        n = DONE + 2;
        while (!done && n < 4 * DONE) begin
            @(negedge clk);
            n++;
        end
        chk(n == 2 * DONE + 1, "R11", "second read length", 32'(n), 32'(2 * DONE + 1));
        chk(rdata === mem_word(b), "R11", "second read word", 32'(rdata), 32'(mem_word(b)));
        chk(ee_frame === exp_frame(b), "R3", "second frame", 32'(ee_frame), 32'(exp_frame(b)));
        prev_word = mem_word(b);
    endtask

    task automatic test_hold();
        for (int i = 0; i < 9; i++) @(negedge clk);
        chk(rdata === prev_word && !done && !busy, "R8", "word held while idle",
            32'(rdata), 32'(prev_word));
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_read(7'd0);
        test_read(7'd127);
        test_read(7'h55);
        test_hold();
        test_read(7'h2A);
        test_ignore_busy(7'h11, 7'h6E);
        test_back_to_back(7'h40, 7'h3F);
        test_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule